// File: doc/BRIEF.md
# ALU Flags and Branch Condition Unit

This block adds or subtracts two 8-bit operands, derives the four status flags (carry, sign, zero, overflow) from the arithmetic, and evaluates a 5-bit branch condition code against those flags to produce a branch-taken decision. Subtraction is carried out as A + ~B + 1, so the carry flag reads 1 when no borrow occurred. The condition set covers single-flag tests as well as the unsigned and signed comparisons that follow from the flags of A−B.

Operations enter on a valid/ready stream and results leave on a second valid/ready stream through one register stage. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle, so a stalled consumer back-pressures the producer at once and no result is lost or overwritten. While `out_valid` is high and `out_ready` is low, every output holds its value.

Top module: `fcu_branch_unit`

## Requirements
- R1: `out_result` is (A + B) mod 256 when `in_sub`=0 and (A − B) mod 256 when `in_sub`=1, computed as A + ~B + 1.
- R2: `out_carry` is the carry out of bit 7; for subtraction it is 1 exactly when A ≥ B taken as unsigned values.
- R3: `out_sign` equals bit 7 of `out_result`, and `out_zero` is 1 exactly when all 8 result bits are 0.
- R4: `out_ovf` is the XOR of the carry into bit 7 and the carry out of bit 7, that is, signed two's-complement overflow.
- R5: Flag test codes: 1 taken if Z=1, 2 if Z=0, 3 if C=1, 4 if C=0, 5 if S=0, 6 if S=1, 7 if V=1, 8 if V=0.
- R6: Unsigned compare codes, meant after A−B: 9 higher (C=1 and Z=0), 10 higher-or-equal (C=1), 11 lower (C=0), 12 lower-or-equal (C=0 or Z=1), 13 equal (Z=1), 14 not-equal (Z=0).
- R7: Signed compare codes, meant after A−B: 15 greater ((S xor V)=0 and Z=0), 16 greater-or-equal ((S xor V)=0), 17 less ((S xor V)=1), 18 less-or-equal ((S xor V)=1 or Z=1), 19 equal (Z=1), 20 not-equal (Z=0).
- R8: Code 0 and codes 21 to 31 always give `out_taken`=0.
- R9: `in_ready` = !`out_valid` or `out_ready`; an accepted operation appears with `out_valid`=1 on the next cycle, results leave in acceptance order, and all outputs hold steady while `out_valid`=1 and `out_ready`=0.
- R10: After reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_a | input | 8 | Operand A |
| in_b | input | 8 | Operand B |
| in_sub | input | 1 | 1 selects A − B, 0 selects A + B |
| in_cond | input | 5 | Branch condition code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Sum or difference |
| out_carry | output | 1 | Carry flag |
| out_sign | output | 1 | Sign flag |
| out_zero | output | 1 | Zero flag |
| out_ovf | output | 1 | Overflow flag |
| out_taken | output | 1 | Branch condition holds |

## Verification
The assertions assume the producer holds its operation stable only through the cycle of acceptance and the consumer may drop `out_ready` at any time; they check flag consistency with the registered result and the hold-while-stalled rule rather than any input ordering. The stimulus drives inputs only at falling edges, sweeps all 32 condition codes over operand pairs at the signed and unsigned boundaries (0x7F/0x80, 0x00/0xFF, equal operands), and toggles `out_ready` from a pseudo-random pattern so that stalls land both on and between results.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int DATA_W = 8;
  localparam int COND_W = 5;

  typedef logic [COND_W-1:0] cond_t;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } flags_t;

  // Flag tests
  localparam cond_t CC_ZSET = 5'd1;
  localparam cond_t CC_ZCLR = 5'd2;
  localparam cond_t CC_CSET = 5'd3;
  localparam cond_t CC_CCLR = 5'd4;
  localparam cond_t CC_PLUS = 5'd5;
  localparam cond_t CC_MINS = 5'd6;
  localparam cond_t CC_VSET = 5'd7;
  localparam cond_t CC_VCLR = 5'd8;
  // Unsigned compares after A-B
  localparam cond_t CC_UGT  = 5'd9;
  localparam cond_t CC_UGE  = 5'd10;
  localparam cond_t CC_ULT  = 5'd11;
  localparam cond_t CC_ULE  = 5'd12;
  localparam cond_t CC_UEQ  = 5'd13;
  localparam cond_t CC_UNE  = 5'd14;
  // Signed compares after A-B
  localparam cond_t CC_SGT  = 5'd15;
  localparam cond_t CC_SGE  = 5'd16;
  localparam cond_t CC_SLT  = 5'd17;
  localparam cond_t CC_SLE  = 5'd18;
  localparam cond_t CC_SEQ  = 5'd19;
  localparam cond_t CC_SNE  = 5'd20;
endpackage

// File: rtl/fcu_adder.sv
module fcu_adder
  import fcu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output flags_t       flags
);
  localparam int LOW_W = W - 1;

  logic [W-1:0]   b_eff;
  logic [LOW_W:0] low;
  logic [1:0]     top;
  logic           c_into_msb;

  assign b_eff      = sub ? ~b : b;
  // Lower bits with carry-in, the extra bit is the carry into the MSB (R4)
  assign low        = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, sub};
  assign c_into_msb = low[LOW_W];
  assign top        = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, c_into_msb};

  assign sum     = {top[0], low[LOW_W-1:0]};
  assign flags.c = top[1];
  assign flags.s = top[0];
  assign flags.z = (sum == '0);
  assign flags.v = c_into_msb ^ top[1];
endmodule

// File: rtl/fcu_cond.sv
module fcu_cond
  import fcu_pkg::*;
(
  input  flags_t f,
  input  cond_t  code,
  output logic   taken
);
  logic lt_signed;
  assign lt_signed = f.s ^ f.v;

  always_comb begin
    unique case (code)
      CC_ZSET, CC_UEQ, CC_SEQ: taken = f.z;
      CC_ZCLR, CC_UNE, CC_SNE: taken = ~f.z;
      CC_CSET, CC_UGE:         taken = f.c;
      CC_CCLR, CC_ULT:         taken = ~f.c;
      CC_PLUS:                 taken = ~f.s;
      CC_MINS:                 taken = f.s;
      CC_VSET:                 taken = f.v;
      CC_VCLR:                 taken = ~f.v;
      CC_UGT:                  taken = f.c & ~f.z;
      CC_ULE:                  taken = ~f.c | f.z;
      CC_SGT:                  taken = ~lt_signed & ~f.z;
      CC_SGE:                  taken = ~lt_signed;
      CC_SLT:                  taken = lt_signed;
      CC_SLE:                  taken = lt_signed | f.z;
      default:                 taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcu_branch_unit.sv
module fcu_branch_unit
  import fcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_sub,
  input  logic [COND_W-1:0] in_cond,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic              out_sign,
  output logic              out_zero,
  output logic              out_ovf,
  output logic              out_taken
);
  logic [DATA_W-1:0] sum_d;
  flags_t            flags_d;
  logic              taken_d;
  flags_t            flags_q;
  logic              accept;

  fcu_adder #(.W(DATA_W)) u_add (
    .a(in_a), .b(in_b), .sub(in_sub), .sum(sum_d), .flags(flags_d)
  );

  fcu_cond u_cond (.f(flags_d), .code(in_cond), .taken(taken_d));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_result <= sum_d;
      flags_q    <= flags_d;
      out_taken  <= taken_d;
    end
  end

  assign out_carry = flags_q.c;
  assign out_sign  = flags_q.s;
  assign out_zero  = flags_q.z;
  assign out_ovf   = flags_q.v;

  // R3: sign flag tracks the registered result MSB
  p_sign_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sign == out_result[DATA_W-1]));
  // R3: zero flag tracks an all-zero result
  p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0)));
  // R9: an accepted operation is presented next cycle
  p_accept_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R9: stalled output holds every field
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_taken)
      && $stable(out_carry) && $stable(out_ovf)));
  // R9: empty stage always ready
  p_empty_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R2: for subtraction, an equal pair gives zero with carry set (no borrow)
  p_sub_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sub && in_a == in_b) |=> (out_zero && out_carry));
endmodule

// File: tb/fcu_branch_unit_tb.sv
module fcu_branch_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_a = '0, in_b = '0;
  logic       in_sub = 1'b0;
  logic [4:0] in_cond = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_result;
  logic       out_carry, out_sign, out_zero, out_ovf, out_taken;

  always #2.5 clk = ~clk;

  fcu_branch_unit u_dut (.*);

  typedef struct packed {
    logic [7:0] res;
    logic c, s, z, v, t;
    logic [4:0] code;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic exp_t model(input logic [7:0] a, b, input logic s_op, input logic [4:0] cd);
    exp_t e;
    logic [8:0] full;
    logic [7:0] bx;
    logic c7;
    logic lt_s, lt_u, eq;
    bx = s_op ? ~b : b;
    full = {1'b0, a} + {1'b0, bx} + {8'b0, s_op};
    c7 = (({1'b0, a[6:0]} + {1'b0, bx[6:0]} + {7'b0, s_op}) >> 7) != 0;
    e.res = full[7:0];
    e.c = full[8];
    e.s = full[7];
    e.z = (full[7:0] == 0);
    e.v = c7 ^ full[8];
    e.code = cd;
    // compare outcomes from operand values, valid for subtraction
    lt_u = a < b;
    lt_s = $signed(a) < $signed(b);
    eq = a == b;
    case (cd)
      5'd1:  e.t = e.z;          5'd2:  e.t = !e.z;
      5'd3:  e.t = e.c;          5'd4:  e.t = !e.c;
      5'd5:  e.t = !e.s;         5'd6:  e.t = e.s;
      5'd7:  e.t = e.v;          5'd8:  e.t = !e.v;
      5'd9:  e.t = s_op ? (!lt_u && !eq) : (e.c && !e.z);
      5'd10: e.t = s_op ? !lt_u : e.c;
      5'd11: e.t = s_op ? lt_u : !e.c;
      5'd12: e.t = s_op ? (lt_u || eq) : (!e.c || e.z);
      5'd13, 5'd19: e.t = s_op ? eq : e.z;
      5'd14, 5'd20: e.t = s_op ? !eq : !e.z;
      5'd15: e.t = s_op ? (!lt_s && !eq) : (!(e.s ^ e.v) && !e.z);
      5'd16: e.t = s_op ? !lt_s : !(e.s ^ e.v);
      5'd17: e.t = s_op ? lt_s : (e.s ^ e.v);
      5'd18: e.t = s_op ? (lt_s || eq) : ((e.s ^ e.v) || e.z);
      default: e.t = 1'b0;
    endcase
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic drive(input logic [7:0] a, b, input logic s_op, input logic [4:0] cd);
    bit taken_in;
    taken_in = 1'b0;
    while (!taken_in) begin
      @(negedge clk);
      in_valid = 1'b1; in_a = a; in_b = b; in_sub = s_op; in_cond = cd;
      #1;
      if (in_ready) begin
        exp_q.push_back(model(a, b, s_op, cd));
        taken_in = 1'b1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // consumer back-pressure pattern
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= rst_n && (lfsr[1:0] != 2'b00);
  end

  // monitor: compare results and check stall hold
  exp_t held;
  bit   held_v = 1'b0;
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid) begin
      if (held_v) begin
        chk({out_result, out_taken, out_carry} == {held.res, held.t, held.c},
            "R9 hold", {out_result, out_taken}, {held.res, held.t});
      end
      if (out_ready) begin
        held_v = 1'b0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected output", out_result, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(out_result == e.res, "R1 result", out_result, e.res);
          chk(out_carry == e.c, "R2 carry", out_carry, e.c);
          chk({out_sign, out_zero} == {e.s, e.z}, "R3 sign/zero", {out_sign, out_zero}, {e.s, e.z});
          chk(out_ovf == e.v, "R4 overflow", out_ovf, e.v);
          if (e.code >= 5'd1 && e.code <= 5'd8)
            chk(out_taken == e.t, "R5 flag branch", {e.code, out_taken}, {e.code, e.t});
          else if (e.code >= 5'd9 && e.code <= 5'd14)
            chk(out_taken == e.t, "R6 unsigned branch", {e.code, out_taken}, {e.code, e.t});
          else if (e.code >= 5'd15 && e.code <= 5'd20)
            chk(out_taken == e.t, "R7 signed branch", {e.code, out_taken}, {e.code, e.t});
          else
            chk(out_taken == 1'b0, "R8 unused code", {e.code, out_taken}, {e.code, 1'b0});
        end
      end else begin
        held.res = out_result; held.t = out_taken; held.c = out_carry;
        held_v = 1'b1;
      end
    end
  end

  initial begin
    logic [7:0] edge_v [8];
    edge_v = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h40};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset empty", out_valid, 0);
    rst_n = 1'b1;
    // boundary sweep: every code, subtraction over edge pairs
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int k = 0; k < 32; k += 3)
          drive(edge_v[i], edge_v[j], 1'b1, 5'(k + ((i + j) % 3)));
    // additions at overflow and carry boundaries
    drive(8'h7F, 8'h01, 1'b0, 5'd7);   // R4 signed overflow
    drive(8'hFF, 8'h01, 1'b0, 5'd3);   // R2 carry out, R3 zero
    drive(8'h80, 8'h80, 1'b0, 5'd7);   // R4 negative overflow
    drive(8'h12, 8'h34, 1'b0, 5'd5);
    // pseudo-random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[7:0], r[15:8], r[16], r[21:17]);
    end
    // drain
    repeat (200) begin
      @(negedge clk);
      if (exp_q.size() == 0) break;
    end
    chk(exp_q.size() == 0, "R9 all results delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule